// File: doc/BRIEF.md
# Transmit Enable and Update Controller

This block sits beside a multi-channel transmit datapath and turns raw per-channel control pins into clean, single-cycle strobes. Every channel has a transmit-enable pin and an update pin. Each pin has a polarity that software programs, and each passes through a two-stage synchronizer. When a channel's effective enable goes from idle to active, the block strobes three actions for that channel. It clears the data memory, loads the pending configuration, and optionally flushes the channel pipeline. Serial-data requests coming from the datapath are passed on only while the channel is enabled, unless software chooses to keep them flowing at all times.

The enable can instead come from an internal pattern generator, which software selects. This generator holds two programmed patterns, A and B. Each pattern has an active length and a total length. The generator alternates between A and B each time the current pattern's length runs out. The generator drives all channels at once. Every software register write also produces a one-clock pulse on a synchronization pin, whose polarity is programmable. That pin can be wired to the update pins of other devices so that several devices switch configuration together.

Registers are written through a simple write port with a 3-bit address. Address 0 is the control register. Address 1 holds the polarity bits, address 2 holds the update mask, and addresses 3 to 6 hold the pattern A active length, pattern A total length, pattern B active length and pattern B total length.

Top module: `txu_ctrl_top`

## Requirements
- R1: While reset is low and in the first cycle after it, every strobe output and `tx_active_o` is 0, `ser_req_o` is 0, and `sync_o` is 0.
- R2: Bit c of register 1 inverts the transmit-enable pin of channel c. With the generator off, `tx_active_o[c]` follows the corrected pin level three rising clock edges after the pin changes.
- R3: When a channel's effective enable rises, `ram_clr_o[c]` and `cfg_upd_o[c]` are 1 for exactly one clock. They rise on the same edge as `tx_active_o[c]`.
- R4: `flush_o[c]` pulses together with `ram_clr_o[c]` only when bit 0 of register 0 is 1. Otherwise it stays 0.
- R5: `ser_req_o[c]` equals `ser_req_i[c]` while `tx_active_o[c]` is 1 or bit 1 of register 0 is 1. Otherwise it is 0.
- R6: Bit 4+c of register 1 inverts the update pin of channel c. A rise of the corrected update level pulses `cfg_upd_o[c]` for one clock, three edges later, only if bit c of register 2 is 1.
- R7: When bit 2 of register 0 is 1, all channels take their enable from the generator. The generator is active for the first N cycles of each period, where N is the active length of the current pattern. A total length of 0 counts as 1.
- R8: The generator starts with pattern A whenever it is switched on. It changes from one pattern to the other each time the current pattern's total length completes.
- R9: `sync_o` is 1 for exactly the clock after each register write, and 0 otherwise. Bit 3 of register 0 inverts this output level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| txen_pin | input | 4 | Raw transmit-enable pins, one per channel |
| upd_pin | input | 4 | Raw update pins, one per channel |
| ser_req_i | input | 4 | Serial-data requests from the datapath |
| ser_req_o | output | 4 | Gated serial-data requests |
| tx_active_o | output | 4 | Effective enable state per channel |
| ram_clr_o | output | 4 | Data-memory clear strobe |
| flush_o | output | 4 | Channel flush strobe |
| cfg_upd_o | output | 4 | Configuration load strobe |
| sync_o | output | 1 | Synchronization pulse for other devices |

## Verification
A stale edge-detect register shows up as a missing or doubled `ram_clr_o` pulse. The same fault shows a wrong `tx_active_o` level. Both appear on the very edge where the enable should have risen. A generator counter or pattern phase that has drifted shows up on `tx_active_o` within one pattern period, as an active run of the wrong length or a missed switch between A and B. Wrong polarity or mask state shows up three edges after the next pin change, as a strobe that fires or fails to fire. A wrong gating condition shows up on `ser_req_o` in the same cycle, whenever a request arrives.

// File: rtl/txu_pkg.sv
package txu_pkg;

  typedef enum logic [2:0] {
    ADDR_CTRL  = 3'd0,
    ADDR_POL   = 3'd1,
    ADDR_MASK  = 3'd2,
    ADDR_ON_A  = 3'd3,
    ADDR_PER_A = 3'd4,
    ADDR_ON_B  = 3'd5,
    ADDR_PER_B = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic sync_inv;
    logic gen_sel;
    logic keep_req;
    logic flush_en;
  } ctrl_t;

  // Generator is active while the count is below the active length.
  function automatic logic gen_on_time(input logic [31:0] cnt, input logic [31:0] on_len);
    return cnt < on_len;
  endfunction

  // Period ends on the last count. A length of zero behaves as one.
  function automatic logic gen_period_done(input logic [31:0] cnt, input logic [31:0] per_len);
    return (per_len == 32'd0) || ((cnt + 32'd1) >= per_len);
  endfunction

endpackage

// File: rtl/txu_sync2.sv
module txu_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/txu_regs.sv
module txu_regs
  import txu_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int DW    = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output ctrl_t            ctrl,
  output logic [NCH-1:0]   txen_inv,
  output logic [NCH-1:0]   upd_inv,
  output logic [NCH-1:0]   upd_mask,
  output logic [CNT_W-1:0] on_a,
  output logic [CNT_W-1:0] per_a,
  output logic [CNT_W-1:0] on_b,
  output logic [CNT_W-1:0] per_b,
  output logic             sync_pulse
);
  localparam int CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      txen_inv   <= '0;
      upd_inv    <= '0;
      upd_mask   <= '0;
      on_a       <= '0;
      per_a      <= '0;
      on_b       <= '0;
      per_b      <= '0;
      sync_pulse <= 1'b0;
    end else begin
      sync_pulse <= we;
      if (we) begin
        case (addr)
          ADDR_CTRL:  ctrl     <= ctrl_t'(wdata[CTRL_W-1:0]);
          ADDR_POL: begin
            txen_inv <= wdata[NCH-1:0];
            upd_inv  <= wdata[2*NCH-1:NCH];
          end
          ADDR_MASK:  upd_mask <= wdata[NCH-1:0];
          ADDR_ON_A:  on_a     <= wdata[CNT_W-1:0];
          ADDR_PER_A: per_a    <= wdata[CNT_W-1:0];
          ADDR_ON_B:  on_b     <= wdata[CNT_W-1:0];
          ADDR_PER_B: per_b    <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assert_sync_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> $past(we));

endmodule

// File: rtl/txu_pattern_gen.sv
module txu_pattern_gen
  import txu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] on_a,
  input  logic [CNT_W-1:0] per_a,
  input  logic [CNT_W-1:0] on_b,
  input  logic [CNT_W-1:0] per_b,
  output logic             level,
  output logic             phase_b,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_on;
  logic [CNT_W-1:0] cur_per;

  assign cur_on  = phase_b ? on_b  : on_a;
  assign cur_per = phase_b ? per_b : per_a;
  assign level   = run && gen_on_time(32'(cnt), 32'(cur_on));
  assign wrap    = run && gen_period_done(32'(cnt), 32'(cur_per));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      phase_b <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      phase_b <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      phase_b <= ~phase_b;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end

  assert_phase_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (phase_b != $past(phase_b))) |-> (cnt == '0));

endmodule

// File: rtl/txu_chan.sv
module txu_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic txen_s,
  input  logic upd_s,
  input  logic txen_inv,
  input  logic upd_inv,
  input  logic upd_mask,
  input  logic gen_sel,
  input  logic gen_level,
  input  logic flush_en,
  input  logic keep_req,
  input  logic ser_req_i,
  output logic ser_req_o,
  output logic tx_active_o,
  output logic ram_clr_o,
  output logic flush_o,
  output logic cfg_upd_o
);
  logic en_sel;
  logic en_rise;
  logic upd_act;
  logic upd_q;
  logic upd_rise;

  assign en_sel   = gen_sel ? gen_level : (txen_s ^ txen_inv);
  assign en_rise  = en_sel & ~tx_active_o;
  assign upd_act  = upd_s ^ upd_inv;
  assign upd_rise = upd_act & ~upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_active_o <= 1'b0;
      upd_q       <= 1'b0;
      ram_clr_o   <= 1'b0;
      flush_o     <= 1'b0;
      cfg_upd_o   <= 1'b0;
    end else begin
      tx_active_o <= en_sel;
      upd_q       <= upd_act;
      ram_clr_o   <= en_rise;
      flush_o     <= en_rise & flush_en;
      cfg_upd_o   <= en_rise | (upd_rise & upd_mask);
    end
  end

  assign ser_req_o = ser_req_i & (tx_active_o | keep_req);

  assert_clear_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_clr_o |=> !ram_clr_o);

  assert_clear_with_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_clr_o |-> (tx_active_o && cfg_upd_o));

  assert_flush_with_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (ram_clr_o && $past(flush_en)));

  assert_masked_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_upd_o && !ram_clr_o) |-> $past(upd_mask));

endmodule

// File: rtl/txu_ctrl_top.sv
module txu_ctrl_top
  import txu_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int DW    = 16,
  parameter int AW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic [NCH-1:0] txen_pin,
  input  logic [NCH-1:0] upd_pin,
  input  logic [NCH-1:0] ser_req_i,
  output logic [NCH-1:0] ser_req_o,
  output logic [NCH-1:0] tx_active_o,
  output logic [NCH-1:0] ram_clr_o,
  output logic [NCH-1:0] flush_o,
  output logic [NCH-1:0] cfg_upd_o,
  output logic           sync_o
);
  ctrl_t            ctrl;
  logic [NCH-1:0]   txen_inv, upd_inv, upd_mask;
  logic [CNT_W-1:0] on_a, per_a, on_b, per_b;
  logic             sync_pulse;
  logic             gen_level, gen_phase_b, gen_wrap;
  logic [NCH-1:0]   txen_s, upd_s;

  txu_regs #(.NCH(NCH), .CNT_W(CNT_W), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .txen_inv(txen_inv), .upd_inv(upd_inv), .upd_mask(upd_mask),
    .on_a(on_a), .per_a(per_a), .on_b(on_b), .per_b(per_b),
    .sync_pulse(sync_pulse)
  );

  txu_pattern_gen #(.CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(ctrl.gen_sel),
    .on_a(on_a), .per_a(per_a), .on_b(on_b), .per_b(per_b),
    .level(gen_level), .phase_b(gen_phase_b), .wrap(gen_wrap)
  );

  txu_sync2 #(.W(NCH)) u_sync_txen (.clk(clk), .rst_n(rst_n), .d(txen_pin), .q(txen_s));
  txu_sync2 #(.W(NCH)) u_sync_upd  (.clk(clk), .rst_n(rst_n), .d(upd_pin),  .q(upd_s));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    txu_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .txen_s(txen_s[c]), .upd_s(upd_s[c]),
      .txen_inv(txen_inv[c]), .upd_inv(upd_inv[c]), .upd_mask(upd_mask[c]),
      .gen_sel(ctrl.gen_sel), .gen_level(gen_level),
      .flush_en(ctrl.flush_en), .keep_req(ctrl.keep_req),
      .ser_req_i(ser_req_i[c]), .ser_req_o(ser_req_o[c]),
      .tx_active_o(tx_active_o[c]), .ram_clr_o(ram_clr_o[c]),
      .flush_o(flush_o[c]), .cfg_upd_o(cfg_upd_o[c])
    );
  end

  assign sync_o = sync_pulse ^ ctrl.sync_inv;

  assert_gen_drives_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl.gen_sel) && ctrl.gen_sel) |-> ((tx_active_o == '0) || (tx_active_o == '1)));

  assert_wrap_only_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gen_wrap |-> ctrl.gen_sel);

endmodule

// File: tb/tb_txu_ctrl_top.sv
module tb_txu_ctrl_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [NCH-1:0] txen_pin = '0, upd_pin = '0, ser_req_i = '0;
  logic [NCH-1:0] ser_req_o, tx_active_o, ram_clr_o, flush_o, cfg_upd_o;
  logic sync_o;

  always #5 clk = ~clk;

  txu_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .txen_pin(txen_pin), .upd_pin(upd_pin), .ser_req_i(ser_req_i),
    .ser_req_o(ser_req_o), .tx_active_o(tx_active_o), .ram_clr_o(ram_clr_o),
    .flush_o(flush_o), .cfg_upd_o(cfg_upd_o), .sync_o(sync_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference state, kept as plain integers and bit lists
  int regs [7];
  bit pin_hist [NCH][$];
  bit upd_hist [NCH][$];
  bit m_act [NCH], m_uprev [NCH], m_clr [NCH], m_fl [NCH], m_cu [NCH];
  int m_cnt;
  bit m_phb, m_sync;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < 7; r++) regs[r] = 0;
    for (int c = 0; c < NCH; c++) begin
      pin_hist[c] = '{0, 0};
      upd_hist[c] = '{0, 0};
      m_act[c] = 0; m_uprev[c] = 0; m_clr[c] = 0; m_fl[c] = 0; m_cu[c] = 0;
    end
    m_cnt = 0; m_phb = 0; m_sync = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      int on_len, per_len;
      bit gen_hi, run;
      run = regs[0][2];
      on_len  = m_phb ? regs[5] : regs[3];
      per_len = m_phb ? regs[6] : regs[4];
      if (per_len == 0) per_len = 1;
      gen_hi = run && (m_cnt < on_len);
      for (int c = 0; c < NCH; c++) begin
        bit lvl, want, ulvl, urise;
        lvl  = pin_hist[c][0] ^ regs[1][c];
        want = run ? gen_hi : lvl;
        ulvl = upd_hist[c][0] ^ regs[1][4+c];
        urise = ulvl && !m_uprev[c];
        m_clr[c] = want && !m_act[c];
        m_fl[c]  = m_clr[c] && regs[0][0];
        m_cu[c]  = m_clr[c] || (urise && regs[2][c]);
        m_act[c] = want;
        m_uprev[c] = ulvl;
        void'(pin_hist[c].pop_front());
        pin_hist[c].push_back(txen_pin[c]);
        void'(upd_hist[c].pop_front());
        upd_hist[c].push_back(upd_pin[c]);
      end
      if (!run) begin
        m_cnt = 0; m_phb = 0;
      end else if (m_cnt + 1 >= per_len) begin
        m_cnt = 0; m_phb = !m_phb;
      end else begin
        m_cnt++;
      end
      m_sync = cfg_we;
      if (cfg_we && cfg_addr < 7) regs[cfg_addr] = int'(cfg_wdata);
    end
    #1;
    if (!done) begin
      if (!rst_n) begin
        chk("R1", int'(tx_active_o), 0, "active in reset");
        chk("R1", int'(ram_clr_o | flush_o | cfg_upd_o), 0, "strobes in reset");
        chk("R1", int'(sync_o), 0, "sync in reset");
      end else begin
        for (int c = 0; c < NCH; c++) begin
          string tg;
          tg = regs[0][2] ? (m_phb ? "R8" : "R7") : "R2";
          chk(tg,   int'(tx_active_o[c]), int'(m_act[c]), $sformatf("active ch%0d", c));
          chk("R3", int'(ram_clr_o[c]), int'(m_clr[c]), $sformatf("clear ch%0d", c));
          chk("R4", int'(flush_o[c]), int'(m_fl[c]), $sformatf("flush ch%0d", c));
          chk("R6", int'(cfg_upd_o[c]), int'(m_cu[c]), $sformatf("update ch%0d", c));
          chk("R5", int'(ser_req_o[c]), int'(ser_req_i[c] && (m_act[c] || regs[0][1])),
              $sformatf("request ch%0d", c));
        end
        chk("R9", int'(sync_o), int'(m_sync ^ regs[0][3]), "sync");
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      ser_req_i = ser_req_i + 4'd3;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R4 flush on, R6 mask for channels 0 and 2
    wr(0, 16'h0001);
    wr(2, 16'h0005);
    idle(3);
    // Directed latency check for R3: pin driven at a falling edge
    @(negedge clk); txen_pin[0] = 1'b1;
    repeat (3) @(posedge clk);
    #2 chk("R3", int'(ram_clr_o[0]), 1, "clear on third edge");
    chk("R4", int'(flush_o[0]), 1, "flush on third edge");
    @(posedge clk); #2 chk("R3", int'(ram_clr_o[0]), 0, "clear single cycle");
    idle(4);
    txen_pin = 4'b0110; idle(6);
    txen_pin = 4'b0000; idle(6);
    // R6 update pins, masked and unmasked
    upd_pin = 4'b1111; idle(5);
    upd_pin = 4'b0000; idle(5);
    upd_pin = 4'b0010; idle(5);
    // R2/R6 polarity inversion on txen ch2 and upd ch1
    wr(1, 16'h0024);
    idle(6);
    txen_pin[2] = 1'b1; upd_pin[1] = 1'b0; idle(6);
    txen_pin[2] = 1'b0; idle(6);
    wr(1, 16'h0000);
    // R5 keep requests while idle, R4 flush off
    wr(0, 16'h0002);
    idle(8);
    txen_pin = 4'b1001; idle(6);
    txen_pin = 4'b0000; idle(6);
    wr(0, 16'h0000);
    idle(6);
    // R7/R8 generator patterns
    wr(3, 2); wr(4, 4); wr(5, 1); wr(6, 3);
    wr(0, 16'h0005);
    idle(40);
    wr(4, 0);            // zero length period acts as one
    idle(12);
    wr(5, 3); wr(6, 3);  // always-on pattern B
    idle(20);
    wr(0, 16'h0000); idle(4);
    wr(0, 16'h0004); idle(15);
    // R9 inverted sync
    wr(0, 16'h0008);
    idle(4);
    wr(2, 16'h000F);
    upd_pin = 4'b1111; idle(6);
    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule